// File: doc/BRIEF.md
# UART modem-control loopback unit

This unit is the internal self-test path of a UART. When software sets the loopback-enable bit through a control-register write, the four modem-control outputs that software drives are turned back onto the modem-status flags. The modem-status interrupt group is rebuilt from those flags at the same time. The external receive input is cut off. Every transmitted character, and every newly asserted send-break, is fed back into the receive buffer instead.

With loopback off, the status flags follow the external modem lines through a two-stage synchronizer. The receive buffer then takes characters and breaks from the external receiver. Only one entry per cycle leaves the unit toward the receive buffer, and only when the buffer reports room. An entry offered while the buffer is full is lost.

Top module: `uart_mdm_loopback`

## Requirements
- R1: After reset, loopback is off, `mdm_flags` and `ms_int` read 0 (external lines held at 0) and `push_valid` is 0.
- R2: A control write with `ctl_lbe`=1 makes `mdm_flags` equal `ctl_mdm` from the next clock edge, including the write that first enables loopback. Index order is bit0 ring indicator from Out2, bit1 clear-to-send from RTS, bit2 carrier detect from Out1, bit3 data-set-ready from DTR.
- R3: A control write with `ctl_lbe`=1 first clears all four `ms_int` bits, then sets each bit whose new flag is 1, so `ms_int` equals `ctl_mdm` after the edge. Any other cycle leaves `ms_int` unchanged.
- R4: With loopback off, `mdm_flags` shows `ext_mdm` through two flip-flops. A change is not visible after one edge and is visible after the second.
- R5: With loopback on, `tx_wr` pushes `tx_data` with `push_break`=0, on the edge that follows.
- R6: With loopback on, external receive characters and breaks are discarded. With loopback off, they are pushed with their break marker, and `tx_wr` pushes nothing.
- R7: With loopback on, a 0-to-1 change of `brk_level` pushes an entry with `push_break`=1 and data 0. A 1-to-0 change pushes nothing, and so does a rise while loopback is off. If `tx_wr` arrives in the same cycle as a rise, the character is pushed and the break is dropped.
- R8: While `rx_space` is 0, no push is issued, and the offered entry is dropped, not retried.
- R9: A control write with `ctl_lbe`=0 returns `mdm_flags` to the synchronized external lines on the next edge and leaves `ms_int` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_lbe | input | 1 | Loopback-enable value being written |
| ctl_mdm | input | 4 | Modem-control outputs being written (DTR, Out1, RTS, Out2 from bit3 down) |
| brk_level | input | 1 | Current send-break bit |
| ext_mdm | input | 4 | Asynchronous external modem status lines (DSR, DCD, CTS, RI from bit3 down) |
| tx_wr | input | 1 | Transmit data write strobe |
| tx_data | input | DW | Transmit character |
| ext_rx_valid | input | 1 | External receiver has an entry |
| ext_rx_data | input | DW | External received character |
| ext_rx_break | input | 1 | External entry is a break |
| rx_space | input | 1 | Receive buffer can accept an entry |
| mdm_flags | output | 4 | Modem-status flags (DSR, DCD, CTS, RI from bit3 down) |
| ms_int | output | 4 | Modem-status raw interrupt bits, same order |
| push_valid | output | 1 | Receive buffer push |
| push_data | output | DW | Pushed character, 0 when idle |
| push_break | output | 1 | Pushed entry is a break |

## Verification
Control writes, transmit strobes, break edges and external receive entries all show their result one edge after the strobe. A change on the external modem lines needs two edges. Stimulus is applied on the falling clock edge and checked on the next falling edge, so exactly one rising edge lies between them. For the synchronizer, the value is also checked after the first edge, to confirm that it has not yet appeared. Drop and no-push cases are checked in the cycle where the push would have appeared, and again one cycle later.

// File: rtl/uart_mdm_loopback.sv
module uart_mdm_loopback #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          ctl_lbe,
  input  logic [3:0]    ctl_mdm,
  input  logic          brk_level,
  input  logic [3:0]    ext_mdm,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_data,
  input  logic          ext_rx_valid,
  input  logic [DW-1:0] ext_rx_data,
  input  logic          ext_rx_break,
  input  logic          rx_space,
  output logic [3:0]    mdm_flags,
  output logic [3:0]    ms_int,
  output logic          push_valid,
  output logic [DW-1:0] push_data,
  output logic          push_break
);
  localparam int LAST = SYNC_STAGES - 1;

  logic                        lbe_q;
  logic [3:0]                  mdm_q;
  logic                        brk_q;
  logic [SYNC_STAGES-1:0][3:0] sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lbe_q  <= 1'b0;
      mdm_q  <= '0;
      ms_int <= '0;
    end else if (ctl_wr) begin
      lbe_q <= ctl_lbe;
      mdm_q <= ctl_mdm;
      if (ctl_lbe) ms_int <= ctl_mdm;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      brk_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_mdm};
      brk_q  <= brk_level;
    end
  end

  assign mdm_flags = lbe_q ? mdm_q : sync_q[LAST];

  logic          take_tx, take_brk, take_ext, src_valid, src_break;
  logic [DW-1:0] src_data;

  assign take_tx   = lbe_q & tx_wr;
  assign take_brk  = lbe_q & brk_level & ~brk_q & ~tx_wr;
  assign take_ext  = ~lbe_q & ext_rx_valid;
  assign src_valid = take_tx | take_brk | take_ext;
  assign src_break = take_brk | (take_ext & ext_rx_break);
  assign src_data  = take_tx  ? tx_data :
                     take_ext ? ext_rx_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      push_valid <= 1'b0;
      push_data  <= '0;
      push_break <= 1'b0;
    end else if (src_valid && rx_space) begin
      push_valid <= 1'b1;
      push_data  <= src_data;
      push_break <= src_break;
    end else begin
      push_valid <= 1'b0;
      push_data  <= '0;
      push_break <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_mdm_loopback_chk.sv
module uart_mdm_loopback_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_wr,
  input logic          ctl_lbe,
  input logic [3:0]    ctl_mdm,
  input logic          brk_level,
  input logic          brk_q,
  input logic          lbe_q,
  input logic          tx_wr,
  input logic [DW-1:0] tx_data,
  input logic          rx_space,
  input logic [3:0]    mdm_flags,
  input logic [3:0]    ms_int,
  input logic          push_valid,
  input logic [DW-1:0] push_data,
  input logic          push_break
);
  assert_loop_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_lbe |=> mdm_flags == $past(ctl_mdm));

  assert_int_rebuild_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_lbe |=> ms_int == $past(ctl_mdm));

  assert_int_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_wr && ctl_lbe) |=> $stable(ms_int));

  assert_tx_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lbe_q && tx_wr && rx_space |=> push_valid && !push_break && push_data == $past(tx_data));

  assert_ext_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lbe_q && !tx_wr |=> !push_valid || push_break);

  assert_brk_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lbe_q && !tx_wr && rx_space && brk_level && !brk_q |=> push_valid && push_break && push_data == '0);

  assert_no_space_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_space |=> !push_valid);
endmodule

bind uart_mdm_loopback uart_mdm_loopback_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_lbe(ctl_lbe), .ctl_mdm(ctl_mdm),
  .brk_level(brk_level), .brk_q(brk_q), .lbe_q(lbe_q), .tx_wr(tx_wr), .tx_data(tx_data),
  .rx_space(rx_space), .mdm_flags(mdm_flags), .ms_int(ms_int), .push_valid(push_valid),
  .push_data(push_data), .push_break(push_break)
);

// File: tb/test_uart_mdm_loopback.sv
module test_uart_mdm_loopback;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 0, ctl_lbe = 0, brk_level = 0, tx_wr = 0;
  logic ext_rx_valid = 0, ext_rx_break = 0, rx_space = 1;
  logic [3:0] ctl_mdm = '0, ext_mdm = '0;
  logic [DW-1:0] tx_data = '0, ext_rx_data = '0;
  logic [3:0] mdm_flags, ms_int;
  logic push_valid, push_break;
  logic [DW-1:0] push_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_mdm_loopback #(.DW(DW), .SYNC_STAGES(2)) i_uart_mdm_loopback (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_lbe(ctl_lbe), .ctl_mdm(ctl_mdm),
    .brk_level(brk_level), .ext_mdm(ext_mdm), .tx_wr(tx_wr), .tx_data(tx_data),
    .ext_rx_valid(ext_rx_valid), .ext_rx_data(ext_rx_data), .ext_rx_break(ext_rx_break),
    .rx_space(rx_space), .mdm_flags(mdm_flags), .ms_int(ms_int), .push_valid(push_valid),
    .push_data(push_data), .push_break(push_break)
  );

  // {lbe, mdm, expected flags, expected ms_int}, external lines held at 4'hA
  localparam logic [15:0] VEC [10] = '{
    16'h1000, 16'h1111, 16'h1222, 16'h1444, 16'h1888,
    16'h05A8, 16'h1FFF, 16'h1666, 16'h00A6, 16'h1999
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic lbe, input logic [3:0] mdm);
    @(negedge clk);
    ctl_wr = 1; ctl_lbe = lbe; ctl_mdm = mdm;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic chk_push(input string req, input logic v, input logic [DW-1:0] d, input logic b);
    chk(req, {29'd0, push_valid, push_break, 1'b0} | {24'd0, push_data} << 8,
             {29'd0, v, b, 1'b0} | {24'd0, d} << 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 flags", {28'd0, mdm_flags}, 0);
    chk("R1 ms_int", {28'd0, ms_int}, 0);
    chk("R1 push", {31'd0, push_valid}, 0);
    rst_n = 1;
    ext_mdm = 4'hA;
    repeat (3) @(negedge clk);
    chk("R4 ext synced", {28'd0, mdm_flags}, 32'hA);

    for (int i = 0; i < 10; i++) begin
      ctl_write(VEC[i][12], VEC[i][11:8]);
      chk(VEC[i][12] ? "R2 flags" : "R9 flags", {28'd0, mdm_flags}, {28'd0, VEC[i][7:4]});
      chk("R3 ms_int", {28'd0, ms_int}, {28'd0, VEC[i][3:0]});
    end

    // R4 sync latency with loopback off
    ctl_write(0, 4'h0);
    ext_mdm = 4'h5;
    @(negedge clk);
    chk("R4 one edge old", {28'd0, mdm_flags}, 32'hA);
    @(negedge clk);
    chk("R4 two edges new", {28'd0, mdm_flags}, 32'h5);
    chk("R9 ms_int kept", {28'd0, ms_int}, 32'h9);

    // R6 non-loop external push, tx ignored
    ext_rx_valid = 1; ext_rx_data = 8'h3C; ext_rx_break = 1;
    @(negedge clk);
    ext_rx_valid = 0; ext_rx_break = 0;
    chk_push("R6 ext push", 1, 8'h3C, 1);
    tx_wr = 1; tx_data = 8'h77;
    @(negedge clk);
    tx_wr = 0;
    chk_push("R6 tx not looped", 0, 0, 0);
    brk_level = 1;
    @(negedge clk);
    chk_push("R7 rise outside loop", 0, 0, 0);
    brk_level = 0;
    @(negedge clk);

    // enable loopback
    ctl_write(1, 4'h3);
    chk("R2 enable write", {28'd0, mdm_flags}, 32'h3);
    tx_wr = 1; tx_data = 8'hA5;
    @(negedge clk);
    tx_wr = 0;
    chk_push("R5 loop tx", 1, 8'hA5, 0);
    ext_rx_valid = 1; ext_rx_data = 8'h11; ext_rx_break = 1;
    @(negedge clk);
    ext_rx_valid = 0; ext_rx_break = 0;
    chk_push("R6 ext discarded", 0, 0, 0);
    ext_mdm = 4'hC;
    repeat (3) @(negedge clk);
    chk("R2 flags ignore ext", {28'd0, mdm_flags}, 32'h3);

    // R7 break edges
    brk_level = 1;
    @(negedge clk);
    chk_push("R7 rise push", 1, 0, 1);
    @(negedge clk);
    chk_push("R7 level no repeat", 0, 0, 0);
    brk_level = 0;
    @(negedge clk);
    chk_push("R7 fall none", 0, 0, 0);
    brk_level = 1; tx_wr = 1; tx_data = 8'h42;
    @(negedge clk);
    tx_wr = 0;
    chk_push("R7 tx wins", 1, 8'h42, 0);
    brk_level = 0;
    @(negedge clk);

    // R8 no space drops
    rx_space = 0; tx_wr = 1; tx_data = 8'h99;
    @(negedge clk);
    tx_wr = 0;
    chk_push("R8 blocked", 0, 0, 0);
    rx_space = 1;
    @(negedge clk);
    chk_push("R8 not retried", 0, 0, 0);

    // R9 disable loopback
    ctl_write(0, 4'hF);
    chk("R9 flags back to ext", {28'd0, mdm_flags}, 32'hC);
    chk("R9 ms_int unchanged", {28'd0, ms_int}, 32'h3);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule